// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits between the shared fetch stage and the two major pipes of a superscalar core: an integer pipe and a load/store pipe. Fetch offers up to two instructions in program order. Each one is tagged with a class (data arithmetic, load/store/address, or other) and a destination register. The unit captures the offered pair into a two-entry window. In the following cycle it decides what goes to each pipe, what gets a bubble, and whether fetch must hold.

Pairing is asymmetric. A load/store instruction can share a cycle only when it is second, behind a data arithmetic instruction, and only when the two write different destinations. In every other case the first instruction issues alone. The second instruction stays in the window as the next first candidate, and fetch is held for that cycle. A global stall freezes both pipes and the window together, so no instruction is lost.

Top module: `pair_issue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no instruction issues, both bubble outputs are low and `fetch_hold` is low.
- R2: When the window holds a data arithmetic instruction (class 2'b01) followed by a load/store instruction (class 2'b10) with a different destination, both issue in the same cycle. The first goes to the integer pipe and the second to the load/store pipe, and `fetch_hold` stays low.
- R3: Two data arithmetic instructions never issue together. The first issues alone with a load/store bubble and `fetch_hold` high. The second issues alone in the next cycle.
- R4: A load/store instruction in the first position issues alone, and the integer pipe gets a bubble. Any second instruction is kept and issues alone in the next cycle.
- R5: An arithmetic followed by a load/store with the same destination is split. The arithmetic issues first. The load/store issues exactly one cycle later, alone, with an integer bubble.
- R6: An instruction of class "other" (2'b00 or 2'b11) never pairs in either position. It issues alone on the integer pipe with a load/store bubble.
- R7: While `stall_i` is high, nothing issues, both bubble outputs and `fetch_hold` are high, and the window contents are kept. After release, the held instructions issue as they would have.
- R8: A stream of pairable pairs offered every cycle issues two instructions in every cycle, with `fetch_hold` low throughout.
- R9: With the window empty and no stall, nothing issues and no bubble is raised. A single valid instruction offered alone issues without raising `fetch_hold`.
- R10: A pair offered while `fetch_hold` is low is captured at that clock edge and is considered for issue in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Global stall that freezes both pipes and the window |
| f0_vld | input | 1 | First offered instruction is valid |
| f0_cls | input | 2 | Class of the first instruction: 01 arithmetic, 10 load/store, else other |
| f0_dst | input | DW | Destination register of the first instruction |
| f1_vld | input | 1 | Second offered instruction is valid |
| f1_cls | input | 2 | Class of the second instruction |
| f1_dst | input | DW | Destination register of the second instruction |
| fetch_hold | output | 1 | Fetch must keep its current pair; the offer is not taken this cycle |
| int_vld | output | 1 | An instruction issues to the integer pipe |
| int_cls | output | 2 | Class of the instruction issued to the integer pipe |
| int_dst | output | DW | Destination of the instruction issued to the integer pipe |
| int_bubble | output | 1 | The integer pipe receives a bubble while the other pipe moves or a stall applies |
| ls_vld | output | 1 | An instruction issues to the load/store pipe |
| ls_dst | output | DW | Destination of the instruction issued to the load/store pipe |
| ls_bubble | output | 1 | The load/store pipe receives a bubble while the other pipe moves or a stall applies |

## Verification
The assertions assume that fetch keeps its offer unchanged while `fetch_hold` is high. They also assume that a second slot is never valid unless the first is. The bench keeps to both rules: it changes the offer only on cycles where the window empties or `fetch_hold` is low, and it never drives `f1_vld` without `f0_vld`. It raises `stall_i` only between clock edges, so a frozen cycle never overlaps an issue cycle the bench has already scored.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          f0_vld,
  input  logic [1:0]    f0_cls,
  input  logic [DW-1:0] f0_dst,
  input  logic          f1_vld,
  input  logic [1:0]    f1_cls,
  input  logic [DW-1:0] f1_dst,
  output logic          fetch_hold,
  output logic          int_vld,
  output logic [1:0]    int_cls,
  output logic [DW-1:0] int_dst,
  output logic          int_bubble,
  output logic          ls_vld,
  output logic [DW-1:0] ls_dst,
  output logic          ls_bubble
);
  localparam logic [1:0] C_ARI = 2'b01;
  localparam logic [1:0] C_LDS = 2'b10;

  logic          a_v, b_v;
  logic [1:0]    a_c, b_c;
  logic [DW-1:0] a_d, b_d;
  logic          go, pair, keep_b, a_ls;

  assign a_ls   = (a_c == C_LDS);
  assign go     = a_v & ~stall_i;
  assign pair   = a_v & b_v & (a_c == C_ARI) & (b_c == C_LDS) & (a_d != b_d);
  assign keep_b = go & b_v & ~pair;

  assign int_vld    = go & ~a_ls;
  assign int_cls    = a_c;
  assign int_dst    = a_d;
  assign ls_vld     = go & (a_ls | pair);
  assign ls_dst     = a_ls ? a_d : b_d;
  assign int_bubble = ~int_vld & (ls_vld | stall_i);
  assign ls_bubble  = ~ls_vld & (int_vld | stall_i);
  assign fetch_hold = stall_i | keep_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v <= 1'b0;
      a_c <= '0;
      a_d <= '0;
      b_v <= 1'b0;
      b_c <= '0;
      b_d <= '0;
    end else if (!stall_i) begin
      if (keep_b) begin
        a_v <= 1'b1;
        a_c <= b_c;
        a_d <= b_d;
        b_v <= 1'b0;
      end else begin
        a_v <= f0_vld;
        a_c <= f0_cls;
        a_d <= f0_dst;
        b_v <= f0_vld & f1_vld;
        b_c <= f1_cls;
        b_d <= f1_dst;
      end
    end
  end

  // R2, R5: a shared cycle is always arithmetic then load/store on distinct destinations
  p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld && ls_vld) |-> (int_cls == C_ARI && int_dst != ls_dst && !fetch_hold));

  // R3, R4: a retained instruction issues alone in the next unstalled cycle
  p_retain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold && !stall_i) |=> (stall_i || (int_vld ^ ls_vld)));

  // R7: stall blocks both pipes and holds fetch
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (!int_vld && !ls_vld && fetch_hold));

  // R7: stall keeps the window intact
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(a_v) && $stable(a_d) && $stable(b_v) && $stable(b_d)));

endmodule

// File: tb/pair_issue_tb.sv
module pair_issue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stall_i = 1'b0;
  logic       f0_vld = 1'b0, f1_vld = 1'b0;
  logic [1:0] f0_cls = '0, f1_cls = '0;
  logic [3:0] f0_dst = '0, f1_dst = '0;
  logic       fetch_hold, int_vld, ls_vld, int_bubble, ls_bubble;
  logic [1:0] int_cls;
  logic [3:0] int_dst, ls_dst;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pair_issue #(.DW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .f0_vld(f0_vld), .f0_cls(f0_cls), .f0_dst(f0_dst),
    .f1_vld(f1_vld), .f1_cls(f1_cls), .f1_dst(f1_dst),
    .fetch_hold(fetch_hold),
    .int_vld(int_vld), .int_cls(int_cls), .int_dst(int_dst), .int_bubble(int_bubble),
    .ls_vld(ls_vld), .ls_dst(ls_dst), .ls_bubble(ls_bubble)
  );

  // {f0v,f0c,f0d,f1v,f1c,f1d} then two observed cycles {iv,lv,ib,lb,fh,id,ld}
  localparam logic [39:0] VEC [10] = '{
    {1'b1,2'b01,4'd1, 1'b1,2'b10,4'd2, 5'b11000,4'd1,4'd2, 5'b00000,4'd0,4'd0},
    {1'b1,2'b01,4'd1, 1'b1,2'b01,4'd2, 5'b10011,4'd1,4'd0, 5'b10010,4'd2,4'd0},
    {1'b1,2'b10,4'd3, 1'b1,2'b01,4'd4, 5'b01101,4'd0,4'd3, 5'b10010,4'd4,4'd0},
    {1'b1,2'b01,4'd5, 1'b1,2'b10,4'd5, 5'b10011,4'd5,4'd0, 5'b01100,4'd0,4'd5},
    {1'b1,2'b10,4'd6, 1'b1,2'b10,4'd7, 5'b01101,4'd0,4'd6, 5'b01100,4'd0,4'd7},
    {1'b1,2'b00,4'd8, 1'b1,2'b10,4'd9, 5'b10011,4'd8,4'd0, 5'b01100,4'd0,4'd9},
    {1'b1,2'b01,4'd1, 1'b0,2'b00,4'd0, 5'b10010,4'd1,4'd0, 5'b00000,4'd0,4'd0},
    {1'b1,2'b10,4'd2, 1'b0,2'b00,4'd0, 5'b01100,4'd0,4'd2, 5'b00000,4'd0,4'd0},
    {1'b1,2'b01,4'd3, 1'b1,2'b11,4'd4, 5'b10011,4'd3,4'd0, 5'b10010,4'd4,4'd0},
    {1'b0,2'b00,4'd0, 1'b0,2'b00,4'd0, 5'b00000,4'd0,4'd0, 5'b00000,4'd0,4'd0}
  };
  localparam string TAG [10] = '{"R2","R3","R4","R5","R4","R6","R9","R9","R6","R9"};

  function automatic logic [12:0] obs();
    return {int_vld, ls_vld, int_bubble, ls_bubble, fetch_hold,
            int_vld ? int_dst : 4'd0, ls_vld ? ls_dst : 4'd0};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    n_run++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s got %b exp %b", tag, obs(), exp);
    end
  endtask

  task automatic offer(input logic v0, input logic [1:0] c0, input logic [3:0] d0,
                       input logic v1, input logic [1:0] c1, input logic [3:0] d1);
    f0_vld = v0; f0_cls = c0; f0_dst = d0;
    f1_vld = v1; f1_cls = c1; f1_dst = d1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    offer(1'b1, 2'b01, 4'd1, 1'b1, 2'b10, 4'd2);
    repeat (2) @(negedge clk);
    check("R1", 13'd0);
    offer(1'b0, 2'b00, 4'd0, 1'b0, 2'b00, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 13'd0);

    // table walk (R10: each offer appears one cycle after capture)
    for (int i = 0; i < 10; i++) begin
      offer(VEC[i][39], VEC[i][38:37], VEC[i][36:33], VEC[i][32], VEC[i][31:30], VEC[i][29:26]);
      @(negedge clk);
      check(TAG[i], VEC[i][25:13]);
      offer(1'b0, 2'b00, 4'd0, 1'b0, 2'b00, 4'd0);
      @(negedge clk);
      check(TAG[i], VEC[i][12:0]);
    end

    // R7: stall on a pairable window
    offer(1'b1, 2'b01, 4'd1, 1'b1, 2'b10, 4'd2);
    @(negedge clk);
    offer(1'b0, 2'b00, 4'd0, 1'b0, 2'b00, 4'd0);
    stall_i = 1'b1; #1;
    check("R7", {5'b00111, 4'd0, 4'd0});
    @(negedge clk);
    check("R7", {5'b00111, 4'd0, 4'd0});
    stall_i = 1'b0; #1;
    check("R7", {5'b11000, 4'd1, 4'd2});
    @(negedge clk);
    check("R9", 13'd0);

    // R7: stall while a retained instruction waits
    offer(1'b1, 2'b01, 4'd5, 1'b1, 2'b01, 4'd6);
    @(negedge clk);
    check("R3", {5'b10011, 4'd5, 4'd0});
    offer(1'b0, 2'b00, 4'd0, 1'b0, 2'b00, 4'd0);
    @(negedge clk);
    stall_i = 1'b1; #1;
    check("R7", {5'b00111, 4'd0, 4'd0});
    @(negedge clk);
    stall_i = 1'b0; #1;
    check("R7", {5'b10010, 4'd6, 4'd0});
    @(negedge clk);
    check("R9", 13'd0);

    // R8: back-to-back pairs
    offer(1'b1, 2'b01, 4'd1, 1'b1, 2'b10, 4'd2);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R8", {5'b11000, 4'(2*k-1), 4'(2*k)});
      if (k < 4) offer(1'b1, 2'b01, 4'(2*k+1), 1'b1, 2'b10, 4'(2*k+2));
      else       offer(1'b0, 2'b00, 4'd0, 1'b0, 2'b00, 4'd0);
    end
    @(negedge clk);
    check("R9", 13'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule